// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block switches the supply of the downstream ports of a USB hub. Each port has its own power-enable output, which goes to an external power switch, and its own active-low overcurrent input, which comes back from that switch. Hub logic sends single-cycle power-on and power-off requests per port, standing in for the hub-class port-feature commands. The block returns per-port status bits for power, current overcurrent, and a sticky overcurrent-change flag.

The block runs in one of two modes. In per-port mode every port is switched and protected on its own. In ganged mode the ports form one group: any request acts on the whole group, and overcurrent on any port shuts down the whole group. The mode comes either from a dedicated pin or from bit 14 of configuration word 0, which a serial-memory loader supplies. A source-select input chooses between the two. The block latches the mode when the loader signals completion. Every overcurrent input passes through a two-flop synchronizer and a debounce counter before it has any effect.

Top module: `hub_port_power`

## Requirements
- R1: While reset is asserted, and until `cfg_done` has been seen high, every `port_pwr_en` bit is 0 and power-on requests are ignored.
- R2: On the first cycle that `cfg_done` is high, the block latches the ganged mode from `gang_pin` if `mode_src_pin` is 1, or from `cfg_word0[14]` if `mode_src_pin` is 0 (1 = ganged). Later changes to these inputs have no effect until the next reset.
- R3: In per-port mode, a `pwr_on_req[i]` pulse turns on port i and a `pwr_off_req[i]` pulse turns it off. Other ports are not affected. If both arrive in the same cycle, off wins.
- R4: `oc_n[i]` is active low. A level change is acted on only after the synchronized level has differed from the filtered level for DEB_CYCLES consecutive cycles. A low pulse shorter than that has no effect.
- R5: In per-port mode, a filtered overcurrent on port i turns off port i only. If port i was powered, it also sets `stat_oc_chg[i]`. `stat_oc[i]` follows the filtered overcurrent.
- R6: A power-on request is ignored while overcurrent is active. Releasing the overcurrent does not restore power. A new power-on request after the release does.
- R7: A set `stat_oc_chg` bit stays set until the matching `oc_chg_clr` bit is pulsed. In ganged mode, any clear bit clears all flags.
- R8: In ganged mode, a power-on request on any port turns on every port, and a power-off request on any port turns off every port.
- R9: In ganged mode, overcurrent on any port turns off every port. Every `stat_oc` bit then reports the group overcurrent, and every `stat_oc_chg` bit is set if the group was powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Loader has finished; configuration is valid |
| mode_src_pin | input | 1 | 1: mode from `gang_pin`; 0: mode from `cfg_word0[14]` |
| gang_pin | input | 1 | Ganged-mode pin setting |
| cfg_word0 | input | 16 | Configuration word 0 from the loader |
| pwr_on_req | input | NUM_PORTS | Per-port power-on request pulses |
| pwr_off_req | input | NUM_PORTS | Per-port power-off request pulses |
| oc_chg_clr | input | NUM_PORTS | Per-port clear pulses for the overcurrent-change flags |
| oc_n | input | NUM_PORTS | Active-low overcurrent inputs from the power switches |
| port_pwr_en | output | NUM_PORTS | Power-enable outputs to the power switches |
| stat_pwr | output | NUM_PORTS | Power status per port |
| stat_oc | output | NUM_PORTS | Filtered overcurrent status per port |
| stat_oc_chg | output | NUM_PORTS | Sticky overcurrent-change flags per port |

## Verification
The bench builds the block with four ports and DEB_CYCLES = 4. With this debounce value, a filter-boundary test is short: a low pulse of three cycles must be ignored, and a pulse of exactly four cycles must take effect. The same short window lets the vector table run a complete sequence in per-port mode: overcurrent, a rejected power-on, release, clear, and a new power-on. The bench then resets the block several times to cover both mode sources, with the pin and the word bit set to opposite values so that the chosen source is visible. The ganged-mode runs use the same settings.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef struct packed {
        logic ready;
        logic gang;
    } mode_st_t;

endpackage

// File: rtl/hpc_oc_filter.sv
module hpc_oc_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n_in,
    output logic oc_flt
);
    localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ~oc_n_in;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(DEB_CYCLES - 1)) begin
            st_d.filt = st_q.s2;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc_flt = st_q.filt;

    // R4
    flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> ($past(st_q.cnt) == CW'(DEB_CYCLES - 1)));

endmodule

// File: rtl/hpc_mode_sel.sv
module hpc_mode_sel
    import hpc_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int GANG_BIT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done,
    input  logic             mode_src_pin,
    input  logic             gang_pin,
    input  logic [CFG_W-1:0] cfg_word0,
    output logic             cfg_ready,
    output logic             gang_mode
);
    mode_st_t m_d, m_q;
    logic     cfg_unused;

    assign cfg_unused = ^cfg_word0;

    always_comb begin
        m_d = m_q;
        if (cfg_done && !m_q.ready) begin
            m_d.ready = 1'b1;
            m_d.gang  = mode_src_pin ? gang_pin : cfg_word0[GANG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign cfg_ready = m_q.ready;
    assign gang_mode = m_q.gang;

    // R2
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.ready && $past(m_q.ready)) |-> $stable(m_q.gang));

endmodule

// File: rtl/hub_port_power.sv
module hub_port_power #(
    parameter int NUM_PORTS  = 4,
    parameter int DEB_CYCLES = 16,
    parameter int CFG_W      = 16,
    parameter int GANG_BIT   = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_done,
    input  logic                 mode_src_pin,
    input  logic                 gang_pin,
    input  logic [CFG_W-1:0]     cfg_word0,
    input  logic [NUM_PORTS-1:0] pwr_on_req,
    input  logic [NUM_PORTS-1:0] pwr_off_req,
    input  logic [NUM_PORTS-1:0] oc_chg_clr,
    input  logic [NUM_PORTS-1:0] oc_n,
    output logic [NUM_PORTS-1:0] port_pwr_en,
    output logic [NUM_PORTS-1:0] stat_pwr,
    output logic [NUM_PORTS-1:0] stat_oc,
    output logic [NUM_PORTS-1:0] stat_oc_chg
);
    typedef struct packed {
        logic [NUM_PORTS-1:0] pwr;
        logic [NUM_PORTS-1:0] chg;
    } port_st_t;

    port_st_t             p_d, p_q;
    logic [NUM_PORTS-1:0] oc_f;
    logic                 cfg_ready;
    logic                 gang_mode;

    hpc_mode_sel #(
        .CFG_W    (CFG_W),
        .GANG_BIT (GANG_BIT)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_done     (cfg_done),
        .mode_src_pin (mode_src_pin),
        .gang_pin     (gang_pin),
        .cfg_word0    (cfg_word0),
        .cfg_ready    (cfg_ready),
        .gang_mode    (gang_mode)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_flt
        hpc_oc_filter #(
            .DEB_CYCLES (DEB_CYCLES)
        ) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc_n_in (oc_n[i]),
            .oc_flt  (oc_f[i])
        );
    end

    always_comb begin
        p_d = p_q;
        if (!cfg_ready) begin
            p_d = '0;
        end else if (gang_mode) begin
            if (|oc_chg_clr) p_d.chg = '0;
            if (|oc_f) begin
                if (|p_q.pwr) p_d.chg = '1;
                p_d.pwr = '0;
            end else if (|pwr_off_req) begin
                p_d.pwr = '0;
            end else if (|pwr_on_req) begin
                p_d.pwr = '1;
            end
        end else begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (oc_chg_clr[i]) p_d.chg[i] = 1'b0;
                if (oc_f[i]) begin
                    if (p_q.pwr[i]) p_d.chg[i] = 1'b1;
                    p_d.pwr[i] = 1'b0;
                end else if (pwr_off_req[i]) begin
                    p_d.pwr[i] = 1'b0;
                end else if (pwr_on_req[i]) begin
                    p_d.pwr[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign port_pwr_en = p_q.pwr;
    assign stat_pwr    = p_q.pwr;
    assign stat_oc_chg = p_q.chg;
    assign stat_oc     = gang_mode ? {NUM_PORTS{|oc_f}} : oc_f;

    // R1
    pre_cfg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> (port_pwr_en == '0));

    // R8
    gang_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gang_mode |-> (p_q.pwr == '0 || p_q.pwr == '1));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        // R5
        oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oc_f[i] |=> !port_pwr_en[i]);

        // R7
        chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ready && p_q.chg[i] && oc_chg_clr == '0) |=> p_q.chg[i]);

        // R9
        gang_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gang_mode && oc_f[i]) |=> (port_pwr_en == '0));
    end

endmodule

// File: tb/hub_port_power_tb.sv
module hub_port_power_tb;
    localparam int NP  = 4;
    localparam int DEB = 4;
    localparam int SETTLE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_done = 1'b0;
    logic          mode_src_pin = 1'b0;
    logic          gang_pin = 1'b0;
    logic [15:0]   cfg_word0 = '0;
    logic [NP-1:0] pwr_on_req = '0;
    logic [NP-1:0] pwr_off_req = '0;
    logic [NP-1:0] oc_chg_clr = '0;
    logic [NP-1:0] oc_n = '1;
    logic [NP-1:0] port_pwr_en, stat_pwr, stat_oc, stat_oc_chg;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hub_port_power #(
        .NUM_PORTS  (NP),
        .DEB_CYCLES (DEB)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_done     (cfg_done),
        .mode_src_pin (mode_src_pin),
        .gang_pin     (gang_pin),
        .cfg_word0    (cfg_word0),
        .pwr_on_req   (pwr_on_req),
        .pwr_off_req  (pwr_off_req),
        .oc_chg_clr   (oc_chg_clr),
        .oc_n         (oc_n),
        .port_pwr_en  (port_pwr_en),
        .stat_pwr     (stat_pwr),
        .stat_oc      (stat_oc),
        .stat_oc_chg  (stat_oc_chg)
    );

    // {on, off, oc_n, clr, exp_pwr, exp_oc, exp_chg}, per-port mode
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {4'b0011, 4'b0000, 4'b1111, 4'b0000, 4'b0011, 4'b0000, 4'b0000}, // R3
        {4'b1100, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b0000}, // R3
        {4'b0000, 4'b0101, 4'b1111, 4'b0000, 4'b1010, 4'b0000, 4'b0000}, // R3
        {4'b0000, 4'b0000, 4'b1101, 4'b0000, 4'b1000, 4'b0010, 4'b0010}, // R5
        {4'b0010, 4'b0000, 4'b1101, 4'b0000, 4'b1000, 4'b0010, 4'b0010}, // R6
        {4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b1000, 4'b0000, 4'b0010}, // R6
        {4'b0000, 4'b0000, 4'b1111, 4'b0010, 4'b1000, 4'b0000, 4'b0000}, // R7
        {4'b0010, 4'b0000, 4'b1111, 4'b0000, 4'b1010, 4'b0000, 4'b0000}, // R6
        {4'b0000, 4'b0000, 4'b0111, 4'b0000, 4'b0010, 4'b1000, 4'b1000}, // R5
        {4'b0000, 4'b0010, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1000}  // R7
    };

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NP-1:0] on, input logic [NP-1:0] off, input logic [NP-1:0] clr);
        @(negedge clk);
        pwr_on_req = on; pwr_off_req = off; oc_chg_clr = clr;
        @(negedge clk);
        pwr_on_req = '0; pwr_off_req = '0; oc_chg_clr = '0;
    endtask

    task automatic restart(input logic src, input logic pin, input logic [15:0] word);
        @(negedge clk);
        rst_n = 1'b0; cfg_done = 1'b0; oc_n = '1;
        mode_src_pin = src; gang_pin = pin; cfg_word0 = word;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        cfg_done = 1'b1;
        wait_cyc(3);
    endtask

    initial begin
        #(5 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state and requests before configuration
        wait_cyc(3);
        check("R1 reset pwr", port_pwr_en, 4'b0000);
        check("R1 reset chg", stat_oc_chg, 4'b0000);
        rst_n = 1'b1;
        wait_cyc(2);
        pulse(4'b1111, 4'b0000, 4'b0000);
        wait_cyc(3);
        check("R1 pre-cfg request ignored", port_pwr_en, 4'b0000);

        // R2: word bit 14 = 0 selected over gang_pin = 1 -> per-port
        restart(1'b0, 1'b1, 16'h0000);
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            oc_n = VEC[v][19:16];
            pulse(VEC[v][27:24], VEC[v][23:20], VEC[v][15:12]);
            wait_cyc(SETTLE);
            check($sformatf("R3/R5/R6/R7 vec%0d pwr", v), stat_pwr, VEC[v][11:8]);
            check($sformatf("R5 vec%0d oc", v), stat_oc, VEC[v][7:4]);
            check($sformatf("R7 vec%0d chg", v), stat_oc_chg, VEC[v][3:0]);
        end
        check("R1 enable mirrors status", port_pwr_en, stat_pwr);

        // R3: off wins over on in the same cycle
        pulse(4'b0001, 4'b0001, 4'b0000);
        wait_cyc(2);
        check("R3 off wins", stat_pwr, 4'b0000);

        // R4: glitch of DEB-1 cycles ignored, DEB cycles acted on
        pulse(4'b1111, 4'b0000, 4'b1111);
        wait_cyc(2);
        oc_n = 4'b1110;
        wait_cyc(DEB - 1);
        oc_n = 4'b1111;
        wait_cyc(SETTLE);
        check("R4 short glitch pwr", stat_pwr, 4'b1111);
        check("R4 short glitch chg", stat_oc_chg, 4'b0000);
        oc_n = 4'b1110;
        wait_cyc(DEB);
        oc_n = 4'b1111;
        wait_cyc(SETTLE);
        check("R4 full-length pulse pwr", stat_pwr, 4'b1110);
        check("R4 full-length pulse chg", stat_oc_chg, 4'b0001);

        // R2: pin selected (gang_pin=1) over word bit 14 = 0 -> ganged
        restart(1'b1, 1'b1, 16'h0000);
        pulse(4'b0100, 4'b0000, 4'b0000);
        wait_cyc(2);
        check("R8 ganged on", stat_pwr, 4'b1111);
        @(negedge clk);
        oc_n = 4'b1110;
        wait_cyc(SETTLE);
        check("R9 ganged oc pwr", port_pwr_en, 4'b0000);
        check("R9 ganged oc status", stat_oc, 4'b1111);
        check("R9 ganged oc chg", stat_oc_chg, 4'b1111);
        pulse(4'b0010, 4'b0000, 4'b0000);
        wait_cyc(2);
        check("R6 ganged on during oc", stat_pwr, 4'b0000);
        @(negedge clk);
        oc_n = 4'b1111;
        wait_cyc(SETTLE);
        check("R6 ganged release stays off", stat_pwr, 4'b0000);
        pulse(4'b0000, 4'b0000, 4'b1000);
        wait_cyc(2);
        check("R7 ganged clear all", stat_oc_chg, 4'b0000);
        pulse(4'b1000, 4'b0000, 4'b0000);
        wait_cyc(2);
        check("R8 ganged re-on", stat_pwr, 4'b1111);
        pulse(4'b0000, 4'b0001, 4'b0000);
        wait_cyc(2);
        check("R8 ganged off", stat_pwr, 4'b0000);

        // R2: word bit 14 = 1, pin = 0 -> ganged; later pin change ignored
        restart(1'b0, 1'b0, 16'h4000);
        pulse(4'b0001, 4'b0000, 4'b0000);
        wait_cyc(2);
        check("R2 word bit selects ganged", stat_pwr, 4'b1111);
        @(negedge clk);
        mode_src_pin = 1'b1; cfg_word0 = 16'h0000;
        pulse(4'b0000, 4'b0010, 4'b0000);
        wait_cyc(2);
        check("R2 mode latched", stat_pwr, 4'b0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule